// File: doc/BRIEF.md
# Strobe-Qualified Parallel Capture Interface

This block receives a parallel word, a transfer strobe and one enable per register group from a sending state machine that runs on the same system clock. The strobe goes high only when a transfer takes place and may stay idle for a long time, so it is never used as a clock. Every input is first registered on the falling clock edge, which puts the sample near the middle of each bit period. It is then registered again on the rising edge, so that everything after that point runs on rising edges only.

A small two-state controller watches the re-aligned strobe. When the strobe rises, every group whose re-aligned enable is high copies its slice of the re-aligned word into its held register. That group's update pulse is high for the one cycle after the load. The controller ignores the strobe until it falls again, so a strobe that stays high for several cycles loads each group only once. The number of groups and the width of each group are parameters.

Top module: `strobe_capture`

## Requirements
- R1: A synchronous active-high reset sets every held register and every update pulse to zero.
- R2: Latency. The inputs are sampled on a falling edge. The held registers and update pulses take the new values on the second rising edge after that falling edge: the first rising edge re-aligns the inputs, the second loads.
- R3: On a load, group g, when its enable `grp_en[g]` is high, takes bits `din[g*GW +: GW]` as they stood at the sample where the strobe first appeared high.
- R4: A group whose enable is low at the load sample keeps its previous held value.
- R5: `upd[g]` is high for exactly one cycle, in the cycle where group g's held value has just been loaded. It stays low for groups that were not loaded.
- R6: A strobe that stays high for more than one cycle causes a single load. Changes to data or enables while the strobe stays high have no effect.
- R7: While the strobe is low, changes to data and enables leave the held registers and update pulses unchanged.
- R8: The controller has two states. ST_IDLE moves to ST_ACTIVE on the transition "take", when the re-aligned strobe is high, and the load happens on that transition. ST_ACTIVE moves back to ST_IDLE on the transition "release", when the re-aligned strobe is low. No load takes place in ST_ACTIVE.
- R9: The parameters GROUPS (number of groups) and GW (bits per group) set the port widths: `din` and `held` are GROUPS*GW bits wide, and `grp_en` and `upd` are GROUPS bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared system clock; inputs sampled on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | GROUPS*GW | Parallel data word, group g in bits g*GW +: GW |
| strobe | input | 1 | Transfer strobe, high only while a transfer is in progress |
| grp_en | input | GROUPS | Per-group load enable |
| held | output | GROUPS*GW | Held register groups |
| upd | output | GROUPS | One-cycle update pulse per group |

## Verification
Directed transfers cover each case on its own: all groups enabled, no group enabled, a single group enabled, and alternating groups enabled. Together these separate a correct per-group load from a load that ignores the enables. Strobes held for two and three cycles, with the data and enables changed after the first strobe cycle, separate edge detection from level loading. They also show whether the bits come from the first strobe sample or a later one. Bursts of data and enable changes with the strobe low confirm that no load happens without a strobe. Seeded random transfers mix all of these patterns, and each result is checked against a bench model of the held registers at the exact cycle the latency requirement names.

// File: rtl/strobe_capture_pkg.sv
package strobe_capture_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } cap_state_t;
endpackage

// File: rtl/cap_fall_stage.sv
module cap_fall_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Mid-period sample on the falling edge
    always_ff @(negedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/cap_rise_stage.sv
module cap_rise_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Brings the falling-edge sample back to the rising-edge domain
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/cap_strobe_fsm.sv
module cap_strobe_fsm
    import strobe_capture_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stb_al,
    output logic       load,
    output cap_state_t state
);
    cap_state_t state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (stb_al) begin          // take
                    state_nx = ST_ACTIVE;
                    load     = 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (!stb_al) state_nx = ST_IDLE;   // release
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/cap_group_bank.sv
module cap_group_bank #(
    parameter int GROUPS = 4,
    parameter int GW     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [GROUPS-1:0]    en_al,
    input  logic [GROUPS*GW-1:0] din_al,
    output logic [GROUPS*GW-1:0] held,
    output logic [GROUPS-1:0]    upd
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic take_g;
        assign take_g = load & en_al[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                held[g*GW +: GW] <= '0;
                upd[g]           <= 1'b0;
            end else begin
                upd[g] <= take_g;
                if (take_g) held[g*GW +: GW] <= din_al[g*GW +: GW];
            end
        end
    end
endmodule

// File: rtl/strobe_capture.sv
module strobe_capture
    import strobe_capture_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int GW     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [GROUPS*GW-1:0] din,
    input  logic                 strobe,
    input  logic [GROUPS-1:0]    grp_en,
    output logic [GROUPS*GW-1:0] held,
    output logic [GROUPS-1:0]    upd
);
    localparam int DW = GROUPS * GW;
    localparam int SW = DW + GROUPS + 1;

    logic [SW-1:0] raw_bus, fall_bus, rise_bus;
    logic [DW-1:0] din_al;
    logic [GROUPS-1:0] en_al;
    logic          stb_al;
    logic          load;
    cap_state_t    state;

    assign raw_bus = {strobe, grp_en, din};

    cap_fall_stage #(.W(SW)) u_fall (
        .clk(clk), .rst(rst), .d(raw_bus), .q(fall_bus)
    );

    cap_rise_stage #(.W(SW)) u_rise (
        .clk(clk), .rst(rst), .d(fall_bus), .q(rise_bus)
    );

    assign {stb_al, en_al, din_al} = rise_bus;

    cap_strobe_fsm u_fsm (
        .clk(clk), .rst(rst), .stb_al(stb_al), .load(load), .state(state)
    );

    cap_group_bank #(.GROUPS(GROUPS), .GW(GW)) u_bank (
        .clk(clk), .rst(rst), .load(load), .en_al(en_al),
        .din_al(din_al), .held(held), .upd(upd)
    );
endmodule

// File: rtl/strobe_capture_chk.sv
module strobe_capture_chk
    import strobe_capture_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int GW     = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [GROUPS*GW-1:0] held,
    input logic [GROUPS-1:0]    upd,
    input logic                 stb_al,
    input cap_state_t           state
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (held == '0 && upd == '0));

    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        (upd != '0) |=> (upd == '0));

    // R8
    active_no_load_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE) |=> (upd == '0));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACTIVE && !stb_al) |=> (state == ST_IDLE));

    for (genvar g = 0; g < GROUPS; g++) begin : g_hold
        // R4
        keep_value_chk: assert property (@(posedge clk) disable iff (rst)
            !upd[g] |-> held[g*GW +: GW] == $past(held[g*GW +: GW]));
    end
endmodule

bind strobe_capture strobe_capture_chk #(.GROUPS(GROUPS), .GW(GW)) u_chk (
    .clk(clk), .rst(rst), .held(held), .upd(upd),
    .stb_al(stb_al), .state(state)
);

// File: tb/strobe_capture_bench.sv
module strobe_capture_bench;
    localparam int GROUPS = 4;
    localparam int GW     = 4;
    localparam int DW     = GROUPS * GW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DW-1:0]     din = '0;
    logic              strobe = 1'b0;
    logic [GROUPS-1:0] grp_en = '0;
    logic [DW-1:0]     held;
    logic [GROUPS-1:0] upd;

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] model = '0;

    always #5 clk = ~clk;

    strobe_capture #(.GROUPS(GROUPS), .GW(GW)) u_strobe_capture (
        .clk(clk), .rst(rst), .din(din), .strobe(strobe),
        .grp_en(grp_en), .held(held), .upd(upd)
    );

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old,
                                            logic [DW-1:0] d,
                                            logic [GROUPS-1:0] e);
        logic [DW-1:0] r = old;
        for (int g = 0; g < GROUPS; g++)
            if (e[g]) r[g*GW +: GW] = d[g*GW +: GW];
        return r;
    endfunction

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive after the rising edge; check 4 ns after a rising edge
    task automatic idle_cycles(int n, string req);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #4;
            chk(req, DW'(upd), '0);
            chk(req, held, model);
        end
    endtask

    task automatic send(logic [DW-1:0] d, logic [GROUPS-1:0] e, int len);
        @(posedge clk); #1; din = d; grp_en = e; strobe = 1'b0;
        @(posedge clk); #1; strobe = 1'b1;                    // Q0
        @(posedge clk); #1;                                   // Q1 re-align
        if (len > 1) begin din = ~d; grp_en = ~e; end         // R6 late changes
        else strobe = 1'b0;
        @(posedge clk); #3;                                   // Q2 load
        model = merge(model, d, e);
        chk("R3 R2", held, model);
        chk("R5", DW'(upd), DW'(e));
        for (int i = 2; i < len; i++) begin
            @(posedge clk); #4;
            chk("R6", DW'(upd), '0);
            chk("R6", held, model);
        end
        #1; strobe = 1'b0;
        idle_cycles(3, "R5 R6");
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        din = '1; grp_en = '1; strobe = 1'b1;
        repeat (3) @(posedge clk);
        #4;
        chk("R1", held, '0);
        chk("R1", DW'(upd), '0);
        #1; rst = 1'b0; strobe = 1'b0; din = '0; grp_en = '0;
        idle_cycles(3, "R1");

        // R9 widths: a full-width word with all groups enabled
        send(16'hA5C3, 4'b1111, 1);
        send(16'h1234, 4'b0000, 1);                           // R4
        send(16'hFFFF, 4'b0100, 1);                           // R4 single group
        send(16'h0F0F, 4'b1010, 2);                           // R6
        send(16'h7E81, 4'b0111, 3);                           // R6 long strobe

        // R7: data and enables toggle with strobe low
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1;
            din = DW'($urandom); grp_en = GROUPS'($urandom);
        end
        idle_cycles(4, "R7");

        for (int k = 0; k < 40; k++)
            send(DW'($urandom), GROUPS'($urandom), 1 + ($urandom % 3));

        // R1 reset mid-operation
        @(posedge clk); #1; rst = 1'b1;
        @(posedge clk); @(posedge clk); #4;
        model = '0;
        chk("R1", held, '0);
        chk("R1", DW'(upd), '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule